// File: doc/BRIEF.md
# Four-Slot Wait-Free Clock-Domain Handoff

The block carries the newest data word from a producer running on one clock to a consumer running on another. Neither side waits for the other. Its storage is four word registers, grouped as two banks of two entries. A small set of one-bit control flags steers each side to a register that the other side is not touching.

The producer side raises a strobe with a word, and the word is published a few cycles later. The consumer side raises a request and gets back one whole word, marked by a one-cycle valid pulse.

There is no queueing. A word that is superseded before anyone asks for it is lost. Each control flag that crosses between the domains passes through a two-flop synchronizer. Each side runs its protocol steps one per cycle.

Top module: `four_slot_xfer`

## Requirements
- R1: While rst_ni is low, and right after it is released, rd_valid_o is 0 and rd_data_o is 0.
- R2: A read request served before any write returns the word 0, and rd_valid_o still pulses.
- R3: rd_valid_o pulses high for exactly one read-clock cycle. The pulse comes exactly RD_SETTLE+3 read-clock rising edges after the edge that sampled rd_req_i while the reader was idle. Requests sampled while a read is in progress are ignored.
- R4: Every returned word is exactly one word that was previously presented with wr_en_i, never a mix of two words.
- R5: Returned words never go backwards in write order: a read returns the word of the preceding read, or a later one.
- R6: Once writes have stopped for at least 30 read-clock cycles, a read returns the last word written.
- R7: A strobe that arrives while the writer is busy replaces any word still pending. After the burst has settled, the last word of the burst is the one returned.
- R8: While the reader is fetching, a word store on the write side never targets the register being fetched. They differ in bank, or in entry.
- R9: The write side changes a bank's entry index only in the cycle after the word has been stored in that bank. It changes the newest-bank flag only in the cycle after the entry index was updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both sides |
| wr_en_i | input | 1 | Write strobe, sampled on wclk_i |
| wr_data_i | input | DATA_W | Word to publish |
| rd_req_i | input | 1 | Read request, sampled on rclk_i |
| rd_valid_o | output | 1 | One-cycle pulse marking rd_data_o |
| rd_data_o | output | DATA_W | Returned word, held until the next read |

## Verification
The stimulus runs on two unrelated clocks. The read clock's half-periods are randomized on every edge. Each word written carries a sequence number and a fixed redundant copy of that number, so a mixed or torn word stands out from a stale one.

The bench runs several traffic patterns:
- Sparse random writes against back-to-back reads show whether returned words move backwards in order or cross a bank swap incoherently.
- Random requests toggled during a read show whether they are ignored and whether the pulse timing stays fixed.
- A quiet period after traffic, and a burst of consecutive strobes, show whether the newest word, and not a superseded one, ends up published.

// File: rtl/four_slot_pkg.sv
package four_slot_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_IDX, W_STORE, W_SLOT, W_LAT
  } wr_state_e;

  typedef enum logic [2:0] {
    R_IDLE, R_PUB, R_WAIT, R_IDX, R_FETCH
  } rd_state_e;
endpackage

// File: rtl/four_slot_sync.sv
module four_slot_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/four_slot_wr.sv
module four_slot_wr
  import four_slot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_flag_i,   // reader's bank, synchronized
  input  logic              rd_pair_i,
  input  logic              rd_idx_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              latest_o,
  output logic [1:0]        slot_o,
  output logic              store_o,
  output logic              pair_o,
  output logic              idx_o
);
  localparam int NUM_SLOTS = 4;

  wr_state_e         state_q;
  logic              pend_q, wp_q, wi_q, latest_q;
  logic [1:0]        slot_q;
  logic [DATA_W-1:0] pend_data_q, word_q;
  logic [DATA_W-1:0] mem_q [NUM_SLOTS];
  logic              take;

  assign take = (state_q == W_IDLE) && pend_q;

  // latest strobe wins while the step machine is busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else if (en_i) begin
      pend_q      <= 1'b1;
      pend_data_q <= data_i;
    end else if (take) begin
      pend_q      <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= W_IDLE;
      wp_q     <= 1'b0;
      wi_q     <= 1'b0;
      word_q   <= '0;
      slot_q   <= 2'b00;
      latest_q <= 1'b0;
    end else begin
      unique case (state_q)
        W_IDLE: if (take) begin
          wp_q    <= ~rd_flag_i;
          word_q  <= pend_data_q;
          state_q <= W_IDX;
        end
        W_IDX: begin
          wi_q    <= ~slot_q[wp_q];
          state_q <= W_STORE;
        end
        W_STORE: state_q <= W_SLOT;
        W_SLOT: begin
          slot_q[wp_q] <= wi_q;
          state_q      <= W_LAT;
        end
        W_LAT: begin
          latest_q <= wp_q;
          state_q  <= W_IDLE;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign store_o = (state_q == W_STORE);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (store_o && ({wp_q, wi_q} == 2'(g))) mem_q[g] <= word_q;
    end
  end

  assign rd_word_o = mem_q[{rd_pair_i, rd_idx_i}];
  assign latest_o  = latest_q;
  assign slot_o    = slot_q;
  assign pair_o    = wp_q;
  assign idx_o     = wi_q;

  p_slot_after_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != $past(slot_q)) |-> ($past(state_q) == W_SLOT));

  p_latest_after_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latest_q != $past(latest_q)) |-> ($past(state_q) == W_LAT));
endmodule

// File: rtl/four_slot_rd.sv
module four_slot_rd
  import four_slot_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RD_SETTLE = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              latest_i,
  input  logic [1:0]        slot_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              flag_o,
  output logic              pair_o,
  output logic              idx_o,
  output logic              fetch_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(RD_SETTLE + 1);

  rd_state_e         state_q;
  logic              rp_q, ri_q, r_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= R_IDLE;
      rp_q    <= 1'b0;
      ri_q    <= 1'b0;
      r_q     <= 1'b0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        R_IDLE: if (req_i) begin
          rp_q    <= latest_i;
          state_q <= R_PUB;
        end
        R_PUB: begin
          r_q     <= rp_q;
          cnt_q   <= CNT_W'(RD_SETTLE - 1);
          state_q <= R_WAIT;
        end
        // let any write already aimed at this bank finish and resync
        R_WAIT: begin
          if (cnt_q == '0) state_q <= R_IDX;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        R_IDX: begin
          ri_q    <= slot_i[rp_q];
          state_q <= R_FETCH;
        end
        R_FETCH: begin
          data_o  <= word_i;
          valid_o <= 1'b1;
          state_q <= R_IDLE;
        end
        default: state_q <= R_IDLE;
      endcase
    end
  end

  assign flag_o  = r_q;
  assign pair_o  = rp_q;
  assign idx_o   = ri_q;
  assign fetch_o = (state_q == R_FETCH);

  p_valid_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_flag_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {R_WAIT, R_IDX, R_FETCH}) |-> (r_q == rp_q));

  p_valid_after_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(state_q) == R_FETCH));
endmodule

// File: rtl/four_slot_xfer.sv
module four_slot_xfer #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RD_SETTLE   = 12
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              r_flag, r_flag_w;
  logic              latest_w, latest_r;
  logic [1:0]        slot_w, slot_r;
  logic              rd_pair, rd_idx, rd_fetch;
  logic              wr_store, wr_pair, wr_idx;
  logic [DATA_W-1:0] rd_word;

  four_slot_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_r (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(r_flag), .q_o(r_flag_w)
  );

  four_slot_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_ls (
    .clk_i(rclk_i), .rst_ni(rst_ni),
    .d_i({latest_w, slot_w}), .q_o({latest_r, slot_r})
  );

  four_slot_wr #(.DATA_W(DATA_W)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .en_i(wr_en_i), .data_i(wr_data_i),
    .rd_flag_i(r_flag_w), .rd_pair_i(rd_pair), .rd_idx_i(rd_idx),
    .rd_word_o(rd_word), .latest_o(latest_w), .slot_o(slot_w),
    .store_o(wr_store), .pair_o(wr_pair), .idx_o(wr_idx)
  );

  four_slot_rd #(.DATA_W(DATA_W), .RD_SETTLE(RD_SETTLE)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .req_i(rd_req_i),
    .latest_i(latest_r), .slot_i(slot_r), .word_i(rd_word),
    .flag_o(r_flag), .pair_o(rd_pair), .idx_o(rd_idx), .fetch_o(rd_fetch),
    .valid_o(rd_valid_o), .data_o(rd_data_o)
  );

  p_no_shared_slot_r8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_store && rd_fetch) |-> ((wr_pair != rd_pair) || (wr_idx != rd_idx)));

  p_no_shared_slot_rclk_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (wr_store && rd_fetch) |-> ((wr_pair != rd_pair) || (wr_idx != rd_idx)));
endmodule

// File: tb/four_slot_xfer_bench.sv
module four_slot_xfer_bench;
  localparam int DW  = 32;
  localparam int SET = 12;
  localparam int LAT = SET + 3;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int next_seq = 1, last_seq = 0, last_rd = 0;
  bit wr_run = 1'b0, done = 1'b0;

  four_slot_xfer #(.DATA_W(DW), .SYNC_STAGES(2), .RD_SETTLE(SET)) u_four_slot_xfer (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  always #2 wclk = ~wclk;  // 4-unit period: 250 MHz at 1 ns
  initial forever #($urandom_range(2, 5)) rclk = ~rclk;

  function automatic logic [DW-1:0] mk(int s);
    return {s[15:0], s[15:0] ^ 16'hA5A5};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one read with random requests during busy; returns the word
  task automatic do_read(output logic [DW-1:0] w);
    @(negedge rclk) rd_req = 1'b1;
    @(posedge rclk);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge rclk);
      rd_req = 1'($urandom_range(0, 1));
      chk(rd_valid == 1'b0, "R3 early pulse", DW'(rd_valid), '0);
      @(posedge rclk);
    end
    @(negedge rclk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, "R3 pulse timing", DW'(rd_valid), 1);
    w = rd_data;
    @(posedge rclk);
    @(negedge rclk);
    chk(rd_valid == 1'b0, "R3 pulse width", DW'(rd_valid), '0);
  endtask

  task automatic wr_one();
    wr_en   = 1'b1;
    wr_data = mk(next_seq);
    last_seq = next_seq;
    next_seq++;
  endtask

  initial begin : writer
    forever begin
      @(negedge wclk);
      wr_en = 1'b0;
      if (wr_run && ($urandom_range(0, 5) == 0)) wr_one();
    end
  end

  initial begin : main
    logic [DW-1:0] w;
    logic [15:0]   hi;
    repeat (3) @(negedge rclk);
    chk(rd_valid == 1'b0 && rd_data == '0, "R1 in reset", rd_data, '0);
    rst_n = 1'b1;
    @(negedge rclk);
    chk(rd_valid == 1'b0 && rd_data == '0, "R1 after reset", rd_data, '0);

    do_read(w);
    chk(w == '0, "R2 read before write", w, '0);

    wr_run = 1'b1;
    for (int n = 0; n < 60; n++) begin
      do_read(w);
      hi = w[31:16];
      if (w != '0) begin
        chk(w[15:0] == (hi ^ 16'hA5A5) && int'(hi) < next_seq, "R4 whole word",
            w, mk(int'(hi)));
        chk(int'(hi) >= last_rd, "R5 order", DW'(hi), DW'(last_rd));
        last_rd = int'(hi);
      end
    end
    wr_run = 1'b0;
    repeat (30) @(negedge rclk);
    do_read(w);
    chk(w == mk(last_seq), "R6 quiet read", w, mk(last_seq));

    @(negedge wclk);
    for (int b = 0; b < 6; b++) begin
      wr_one();
      @(negedge wclk);
    end
    wr_en = 1'b0;
    repeat (30) @(negedge rclk);
    do_read(w);
    chk(w == mk(last_seq), "R7 burst last wins", w, mk(last_seq));
    do_read(w);
    chk(w == mk(last_seq), "R5 repeat read", w, mk(last_seq));
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (200000) @(posedge wclk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule